// File: doc/BRIEF.md
# ADC Global Result Register Logic

This block holds the status and result word of a multi-channel successive-approximation ADC controller. A conversion engine reports each finished conversion with a one-cycle completion pulse, a 12-bit result and the number of the channel it converted. The block latches these into one packed 32-bit word that software reads. The word carries a completion flag, an overwrite flag, the channel number and the result.

The completion flag is cleared by a read of the word and by any write to the control register. The overwrite flag is raised only while burst mode is active, when a new result replaces one that software never read. A read clears it. The block also turns control writes into a one-cycle start pulse for the engine. A write that carries the start bit issues a pulse. A write of any kind that lands while a conversion is still in flight also issues a pulse, which restarts the conversion.

Top module: `adc_gr_result_reg`

## Requirements
- R1: Reset clears `data_o` to all zeros and holds `start_o` low.
- R2: Bits 15:4 of `data_o` hold the result of the most recent completion. Bits 3:0, 23:16 and 30:28 always read as zero.
- R3: Bits 26:24 of `data_o` hold, in binary, the channel number of the most recent completion.
- R4: Bit 31 (done) reads 1 in the cycle after a `conv_done_i` pulse.
- R5: A `data_rd_i` cycle with no completion clears bit 31 and bit 27 (overrun) in the next cycle. The result and channel fields are kept.
- R6: A `ctrl_wr_i` cycle with no completion clears bit 31 in the next cycle and leaves bit 27 unchanged.
- R7: A completion in the same cycle as a read or a control write wins. Bit 31 reads 1 with the new result and channel. A completion that coincides with a read does not set bit 27.
- R8: With `burst_i` high, a completion while bit 31 is set and no read is in that cycle sets bit 27.
- R9: With `burst_i` low, a completion never changes bit 27, even if the previous result was unread. The result and channel are still replaced.
- R10: A control write with `ctrl_start_i` high raises `start_o` for exactly one cycle, in the cycle after the write.
- R11: A control write while a conversion is in flight raises `start_o` in the next cycle even with `ctrl_start_i` low. A conversion is in flight from a start pulse until a completion pulse. A write with `ctrl_start_i` low when no conversion is in flight raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_start_i | input | 1 | Start bit value carried by the control write |
| data_rd_i | input | 1 | Data word read strobe |
| burst_i | input | 1 | Burst mode active |
| conv_done_i | input | 1 | Conversion complete pulse from the engine |
| conv_result_i | input | 12 | Result of the finished conversion |
| conv_chan_i | input | 3 | Channel of the finished conversion |
| data_o | output | 32 | Packed data word |
| start_o | output | 1 | One-cycle start pulse to the engine |

## Verification
The bench targets completions that coincide with a read or a control write. A design that let the clear win there would lose a result and leave bit 31 low. The bench also reads back-to-back burst completions with no read between them. Without burst gating on the overwrite flag, the same pattern in normal mode would wrongly raise bit 27. A control write with the start bit low is issued both while a conversion is in flight and while idle. A design with broken restart would either miss the restart pulse or pulse on every write. A reset after the flags are set confirms that the whole word returns to zero.

// File: rtl/adc_gr_pkg.sv
package adc_gr_pkg;
  localparam int DATA_W   = 32;
  localparam int RES_LSB  = 4;
  localparam int CH_LSB   = 24;
  localparam int OV_BIT   = 27;
  localparam int DONE_BIT = 31;
endpackage

// File: rtl/adc_gr_seq.sv
module adc_gr_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic ctrl_start_i,
  input  logic conv_done_i,
  output logic start_o,
  output logic busy_o
);
  logic start_n, busy_q, start_q;

  // restart when written while a conversion is outstanding
  assign start_n = ctrl_wr_i & (ctrl_start_i | (busy_q & ~conv_done_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= start_n;
      if (start_n)          busy_q <= 1'b1;
      else if (conv_done_i) busy_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign busy_o  = busy_q;

  a_r10_start_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(ctrl_wr_i));
  a_r10_start_bit_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_start_i |=> start_o);
  a_r11_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && busy_q && !conv_done_i |=> start_o);
endmodule

// File: rtl/adc_gr_status.sv
module adc_gr_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic data_rd_i,
  input  logic burst_i,
  input  logic conv_done_i,
  output logic done_o,
  output logic ovr_o
);
  logic done_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      // completion has priority over both clear sources
      if (conv_done_i)                  done_q <= 1'b1;
      else if (data_rd_i || ctrl_wr_i)  done_q <= 1'b0;

      if (conv_done_i && burst_i && done_q && !data_rd_i) ovr_q <= 1'b1;
      else if (data_rd_i)                                 ovr_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign ovr_o  = ovr_q;

  a_r4_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> done_q);
  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && !conv_done_i |=> !done_q && !ovr_q);
  a_r6_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !conv_done_i && !data_rd_i |=> !done_q && $stable(ovr_q));
  a_r8_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && burst_i && done_q && !data_rd_i |=> ovr_q);
  a_r7_read_race: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && data_rd_i |=> done_q && !ovr_q);
endmodule

// File: rtl/adc_gr_capture.sv
module adc_gr_capture #(
  parameter int RES_W = 12,
  parameter int CH_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_done_i,
  input  logic [RES_W-1:0] conv_result_i,
  input  logic [CH_W-1:0]  conv_chan_i,
  output logic [RES_W-1:0] result_o,
  output logic [CH_W-1:0]  chan_o
);
  logic [RES_W-1:0] res_q;
  logic [CH_W-1:0]  ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      ch_q  <= '0;
    end else if (conv_done_i) begin
      res_q <= conv_result_i;
      ch_q  <= conv_chan_i;
    end
  end

  assign result_o = res_q;
  assign chan_o   = ch_q;

  a_r2_result_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> res_q == $past(conv_result_i));
  a_r3_chan_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i |=> ch_q == $past(conv_chan_i));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_done_i |=> $stable(res_q) && $stable(ch_q));
endmodule

// File: rtl/adc_gr_result_reg.sv
module adc_gr_result_reg
  import adc_gr_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CH_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_start_i,
  input  logic              data_rd_i,
  input  logic              burst_i,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  input  logic [CH_W-1:0]   conv_chan_i,
  output logic [DATA_W-1:0] data_o,
  output logic              start_o
);
  logic             done_w, ovr_w, busy_w;
  logic [RES_W-1:0] res_w;
  logic [CH_W-1:0]  ch_w;

  adc_gr_seq u_seq (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_start_i, .conv_done_i,
    .start_o, .busy_o(busy_w)
  );

  adc_gr_status u_status (
    .clk_i, .rst_ni, .ctrl_wr_i, .data_rd_i, .burst_i, .conv_done_i,
    .done_o(done_w), .ovr_o(ovr_w)
  );

  adc_gr_capture #(.RES_W(RES_W), .CH_W(CH_W)) u_cap (
    .clk_i, .rst_ni, .conv_done_i, .conv_result_i, .conv_chan_i,
    .result_o(res_w), .chan_o(ch_w)
  );

  always_comb begin
    data_o                     = '0;
    data_o[DONE_BIT]           = done_w;
    data_o[OV_BIT]             = ovr_w;
    data_o[CH_LSB +: CH_W]     = ch_w;
    data_o[RES_LSB +: RES_W]   = res_w;
  end

  a_r9_no_ovr_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_i && !burst_i && !data_rd_i |=> $stable(data_o[OV_BIT]));
  a_r2_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[3:0] == '0 && data_o[23:16] == '0 && data_o[30:28] == '0);
  a_r11_busy_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_w);
endmodule

// File: tb/sim_adc_gr_result_reg.sv
module sim_adc_gr_result_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 0, st = 0, rd = 0, bu = 0, dn = 0;
  logic [11:0] res = '0;
  logic [2:0]  ch = '0;
  logic [31:0] data;
  logic        start;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  adc_gr_result_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(wr), .ctrl_start_i(st),
    .data_rd_i(rd), .burst_i(bu), .conv_done_i(dn), .conv_result_i(res),
    .conv_chan_i(ch), .data_o(data), .start_o(start)
  );

  typedef struct packed {
    logic wr, st, rd, bu, dn;
    logic [11:0] res;
    logic [2:0]  ch;
    logic e_dn, e_ov;
    logic [2:0]  e_ch;
    logic [11:0] e_res;
    logic e_st;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{0,0,0,0,0, 12'h000,3'd0, 0,0,3'd0,12'h000, 0}, // R1 idle
    '{1,1,0,0,0, 12'h000,3'd0, 0,0,3'd0,12'h000, 1}, // R10 start
    '{0,0,0,0,0, 12'h000,3'd0, 0,0,3'd0,12'h000, 0}, // R10 single cycle
    '{0,0,0,0,1, 12'hABC,3'd5, 1,0,3'd5,12'hABC, 0}, // R4 R2 R3
    '{0,0,1,0,0, 12'h000,3'd0, 0,0,3'd5,12'hABC, 0}, // R5
    '{1,1,0,0,0, 12'h000,3'd0, 0,0,3'd5,12'hABC, 1}, // R10
    '{1,0,0,0,0, 12'h000,3'd0, 0,0,3'd5,12'hABC, 1}, // R11 restart
    '{0,0,0,1,1, 12'h123,3'd2, 1,0,3'd2,12'h123, 0}, // R4 burst
    '{0,0,0,1,1, 12'h456,3'd3, 1,1,3'd3,12'h456, 0}, // R8
    '{1,0,0,1,0, 12'h000,3'd0, 0,1,3'd3,12'h456, 0}, // R6 R11 idle
    '{0,0,1,1,0, 12'h000,3'd0, 0,0,3'd3,12'h456, 0}, // R5 ovr clear
    '{0,0,0,1,1, 12'h001,3'd7, 1,0,3'd7,12'h001, 0}, // R3
    '{0,0,1,1,1, 12'hFFF,3'd0, 1,0,3'd0,12'hFFF, 0}, // R7 read race
    '{0,0,0,0,1, 12'h800,3'd1, 1,0,3'd1,12'h800, 0}, // R9
    '{1,0,0,0,1, 12'h0F0,3'd4, 1,0,3'd4,12'h0F0, 0}, // R7 write race
    '{0,0,1,0,0, 12'h000,3'd0, 0,0,3'd4,12'h0F0, 0}  // R5
  };

  function automatic logic [31:0] mk(logic d, logic o, logic [2:0] c, logic [11:0] r);
    logic [31:0] w = '0;
    w[31] = d; w[27] = o; w[26:24] = c; w[15:4] = r;
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] exp_d, logic exp_s);
    checks++;
    if (data !== exp_d || start !== exp_s) begin
      errors++;
      $display("FAIL %s: data=%h start=%b expected data=%h start=%b",
               req, data, start, exp_d, exp_s);
    end
  endtask

  task automatic drive(logic w, logic s, logic r, logic b, logic d,
                       logic [11:0] rs, logic [2:0] c);
    @(negedge clk);
    wr = w; st = s; rd = r; bu = b; dn = d; res = rs; ch = c;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset", 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].wr, TBL[i].st, TBL[i].rd, TBL[i].bu, TBL[i].dn, TBL[i].res, TBL[i].ch);
      chk($sformatf("R2/R3 vector %0d", i),
          mk(TBL[i].e_dn, TBL[i].e_ov, TBL[i].e_ch, TBL[i].e_res), TBL[i].e_st);
    end

    // R9: normal-mode completion over unread result leaves overrun low
    drive(0,0,0,0,1, 12'h00F, 3'd6);
    drive(0,0,0,0,1, 12'hF00, 3'd2);
    chk("R9 no overrun", mk(1,0,3'd2,12'hF00), 1'b0);

    // R8 then R6: write keeps overrun set
    drive(0,0,0,1,1, 12'h3C3, 3'd1);
    chk("R8 overrun", mk(1,1,3'd1,12'h3C3), 1'b0);
    drive(1,0,0,0,0, 12'h000, 3'd0);
    chk("R6 write keeps ovr", mk(0,1,3'd1,12'h3C3), 1'b0);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    wr = 0; rd = 0; dn = 0; bu = 0;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", 32'h0, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule